// File: doc/BRIEF.md
# Correlation Peak Frame Detector

This block sits after a correlator and its magnitude stage. It decides whether one observation window of correlation magnitudes holds a frame. After a start pulse it counts the valid samples of a window of fixed length. It captures the magnitude at one expected sample position and keeps the largest magnitude seen at every other position. When the last sample of the window arrives it applies a relative ratio test. The frame is declared present only when the expected-position value clearly dominates every other value. No noise-floor estimate and no absolute threshold are involved.

An external controller runs the block once per channel. It pulses start with a small channel tag, streams that channel's magnitudes, waits for the done strobe and reads the present flag and the returned tag before it starts the next channel. The block can be restarted at any time. A new start abandons the window in progress.

Top module: `corr_peak_detector`

## Requirements
- R1: After reset, done_o, present_o and chan_tag_o are all 0.
- R2: While no window is running (after reset, or after a window has completed), valid samples are ignored: done_o stays 0 and present_o keeps its value.
- R3: A window is the first WIN_LEN (default 4950) valid samples after a start pulse, numbered 0 upward. done_o is 1 for exactly one cycle, in the cycle after the clock edge that accepts sample WIN_LEN-1.
- R4: With p the sample at index PEAK_IDX (default 375) and m the largest sample at any other index of the window (the first and last indices included), present_o becomes 1 with done_o when 3*p > 4*m, and 0 otherwise.
- R5: The comparison is strict. When 3*p equals 4*m, and in particular when the window is all zeros, the result is absent (present_o = 0).
- R6: present_o holds its value from the done strobe until the next start pulse. It reads 0 in the cycle after a start pulse.
- R7: chan_tag_o shows, from the cycle after a start pulse until the next start pulse, the 2-bit chan_tag_i value sampled with that start.
- R8: Cycles with mag_valid_i = 0 neither advance the sample index nor affect the peak or maximum, whatever mag_i holds.
- R9: A start pulse during a running window discards that window. Counting and tracking restart from index 0, and no done_o is produced for the abandoned window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that opens a new window |
| chan_tag_i | input | TAG_W (2) | Channel tag captured with start_i |
| mag_valid_i | input | 1 | mag_i holds a sample this cycle |
| mag_i | input | MAG_W (24) | Unsigned correlation magnitude |
| done_o | output | 1 | One-cycle strobe when a window decision is ready |
| present_o | output | 1 | Decision: 1 = dominant peak at the expected index |
| chan_tag_o | output | TAG_W (2) | Tag of the window being run or last decided |

## Verification
Each result has a fixed latency. The done strobe and the new present value appear one cycle after the edge that takes the last window sample. A start clears present and loads the tag one cycle after the edge that samples it. A behavioural model in the bench advances on every rising edge from the same inputs, and the outputs are compared with it at every falling edge, so each comparison falls exactly in the cycle its result is due. Directed checks then look at the falling edge right after the final sample and one cycle later. They cover the strict ratio boundary, a maximum at the first and at the last index, invalid cycles that carry large values, samples while idle, and a restart in mid-window.

// File: rtl/corr_peak_pkg.sv
package corr_peak_pkg;

    localparam int DEF_WIN_LEN  = 4950;
    localparam int DEF_PEAK_IDX = 375;
    localparam int DEF_MAG_W    = 24;
    localparam int DEF_TAG_W    = 2;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // 3*p > 4*m computed with one shift-add and one shift; inputs zero-extended.
    function automatic logic beats_three_quarters(input logic [61:0] p, input logic [61:0] m);
        logic [63:0] lhs;
        logic [63:0] rhs;
        lhs = {1'b0, p, 1'b0} + {2'b00, p};
        rhs = {m, 2'b00};
        return lhs > rhs;
    endfunction

endpackage

// File: rtl/pfd_window_ctr.sv
module pfd_window_ctr
    import corr_peak_pkg::*;
#(
    parameter int WIN_LEN  = DEF_WIN_LEN,
    parameter int PEAK_IDX = DEF_PEAK_IDX
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic valid_i,
    output logic accept_o,
    output logic at_peak_o,
    output logic last_o
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] PK_IDX   = CNT_W'(PEAK_IDX);

    phase_e           phase_q;
    logic [CNT_W-1:0] idx_q;

    always_comb begin
        accept_o  = (phase_q == PH_RUN) && valid_i && !start_i;
        at_peak_o = (idx_q == PK_IDX);
        last_o    = accept_o && (idx_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else if (start_i) begin
            phase_q <= PH_RUN;
            idx_q   <= '0;
        end else if (accept_o) begin
            if (idx_q == LAST_IDX) begin
                phase_q <= PH_IDLE;
                idx_q   <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    AST_IDX_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        idx_q < CNT_W'(WIN_LEN)); // R3

    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (phase_q == PH_IDLE)); // R3

    AST_RESTART_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (idx_q == '0 && phase_q == PH_RUN)); // R9

endmodule

// File: rtl/pfd_peak_track.sv
module pfd_peak_track #(
    parameter int MAG_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             accept_i,
    input  logic             at_peak_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [MAG_W-1:0] peak_nxt_o,
    output logic [MAG_W-1:0] max_nxt_o
);
    logic [MAG_W-1:0] peak_q;
    logic [MAG_W-1:0] max_q;

    always_comb begin
        peak_nxt_o = peak_q;
        max_nxt_o  = max_q;
        if (accept_i) begin
            if (at_peak_i) begin
                peak_nxt_o = mag_i;
            end else if (mag_i > max_q) begin
                max_nxt_o = mag_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            peak_q <= '0;
            max_q  <= '0;
        end else begin
            peak_q <= peak_nxt_o;
            max_q  <= max_nxt_o;
        end
    end

    AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (max_q >= $past(max_q))); // R4

    AST_IGNORE_INVALID: assert property (@(posedge clk) disable iff (rst)
        (!accept_i && !clear_i) |=> ($stable(max_q) && $stable(peak_q))); // R8

endmodule

// File: rtl/pfd_ratio_cmp.sv
module pfd_ratio_cmp
    import corr_peak_pkg::*;
#(
    parameter int MAG_W     = 24,
    parameter int RATIO_NUM = 3,
    parameter int RATIO_DEN = 4
) (
    input  logic [MAG_W-1:0] peak_i,
    input  logic [MAG_W-1:0] max_i,
    output logic             pass_o
);
    localparam int NUM_W  = $clog2(RATIO_NUM + 1);
    localparam int DEN_W  = $clog2(RATIO_DEN + 1);
    localparam int PROD_W = MAG_W + ((NUM_W > DEN_W) ? NUM_W : DEN_W);

    generate
        if (RATIO_NUM == 3 && RATIO_DEN == 4 && MAG_W <= 62) begin : g_shift
            assign pass_o = beats_three_quarters(62'(peak_i), 62'(max_i));
        end else begin : g_mult
            logic [PROD_W-1:0] lhs;
            logic [PROD_W-1:0] rhs;
            assign lhs    = PROD_W'(peak_i) * PROD_W'(RATIO_NUM);
            assign rhs    = PROD_W'(max_i) * PROD_W'(RATIO_DEN);
            assign pass_o = lhs > rhs;
        end
    endgenerate

endmodule

// File: rtl/corr_peak_detector.sv
module corr_peak_detector
    import corr_peak_pkg::*;
#(
    parameter int WIN_LEN   = DEF_WIN_LEN,
    parameter int PEAK_IDX  = DEF_PEAK_IDX,
    parameter int MAG_W     = DEF_MAG_W,
    parameter int TAG_W     = DEF_TAG_W,
    parameter int RATIO_NUM = 3,
    parameter int RATIO_DEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [TAG_W-1:0] chan_tag_i,
    input  logic             mag_valid_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic             done_o,
    output logic             present_o,
    output logic [TAG_W-1:0] chan_tag_o
);
    logic             accept_w;
    logic             at_peak_w;
    logic             last_w;
    logic             pass_w;
    logic [MAG_W-1:0] peak_nxt_w;
    logic [MAG_W-1:0] max_nxt_w;

    pfd_window_ctr #(
        .WIN_LEN (WIN_LEN),
        .PEAK_IDX(PEAK_IDX)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .valid_i  (mag_valid_i),
        .accept_o (accept_w),
        .at_peak_o(at_peak_w),
        .last_o   (last_w)
    );

    pfd_peak_track #(
        .MAG_W(MAG_W)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (start_i),
        .accept_i  (accept_w),
        .at_peak_i (at_peak_w),
        .mag_i     (mag_i),
        .peak_nxt_o(peak_nxt_w),
        .max_nxt_o (max_nxt_w)
    );

    pfd_ratio_cmp #(
        .MAG_W    (MAG_W),
        .RATIO_NUM(RATIO_NUM),
        .RATIO_DEN(RATIO_DEN)
    ) u_cmp (
        .peak_i(peak_nxt_w),
        .max_i (max_nxt_w),
        .pass_o(pass_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o     <= 1'b0;
            present_o  <= 1'b0;
            chan_tag_o <= '0;
        end else begin
            done_o <= last_w;
            if (start_i) begin
                present_o  <= 1'b0;
                chan_tag_o <= chan_tag_i;
            end else if (last_w) begin
                present_o <= pass_w;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R3

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        last_w |=> done_o); // R3

    AST_PRESENT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !last_w) |=> $stable(present_o)); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!present_o && !done_o)); // R6

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(chan_tag_o)); // R7

endmodule

// File: tb/corr_peak_detector_test.sv
module corr_peak_detector_test;

    localparam int WIN  = 4950;
    localparam int PIDX = 375;
    localparam int MW   = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [1:0]    chan_tag_i = 2'd0;
    logic          mag_valid_i = 1'b0;
    logic [MW-1:0] mag_i = '0;
    logic          done_o;
    logic          present_o;
    logic [1:0]    chan_tag_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    corr_peak_detector uut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .chan_tag_i (chan_tag_i),
        .mag_valid_i(mag_valid_i),
        .mag_i      (mag_i),
        .done_o     (done_o),
        .present_o  (present_o),
        .chan_tag_o (chan_tag_o)
    );

    // behavioural reference, advanced on each rising edge
    bit      m_run = 0;
    int      m_idx = 0;
    longint  m_peak = 0;
    longint  m_max = 0;
    bit      m_done = 0;
    bit      m_pres = 0;
    int      m_tag = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_run = 0; m_idx = 0; m_peak = 0; m_max = 0;
            m_done = 0; m_pres = 0; m_tag = 0;
        end else begin
            m_done = 0;
            if (start_i) begin
                m_run = 1; m_idx = 0; m_peak = 0; m_max = 0;
                m_pres = 0; m_tag = int'(chan_tag_i);
            end else if (m_run && mag_valid_i) begin
                if (m_idx == PIDX) m_peak = longint'(mag_i);
                else if (longint'(mag_i) > m_max) m_max = longint'(mag_i);
                if (m_idx == WIN - 1) begin
                    m_run = 0;
                    m_done = 1;
                    m_pres = (3 * m_peak > 4 * m_max);
                end
                m_idx++;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R3", "model done_o", int'(done_o), int'(m_done));
            check("R4", "model present_o", int'(present_o), int'(m_pres));
            check("R7", "model chan_tag_o", int'(chan_tag_o), m_tag);
        end
    end

    function automatic int samp(input int kind, input int i);
        case (kind)
            0: return (i == PIDX) ? 1000 : (i * 37) % 700;
            1: return (i == PIDX) ? 400 : ((i == 2000) ? 300 : i % 250);
            2: return (i == PIDX) ? 401 : ((i == 2000) ? 300 : i % 250);
            3: return (i == PIDX) ? 1000 : ((i == 10) ? 800 : i % 500);
            4: return 0;
            5: return (i == PIDX) ? 500 : ((i == WIN - 1) ? 380 : i % 300);
            default: return (i == PIDX) ? 500 : ((i == 0) ? 374 : i % 300);
        endcase
    endfunction

    task automatic do_start(input int tag);
        @(negedge clk);
        start_i = 1'b1;
        chan_tag_i = 2'(tag);
        mag_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check("R6", "present after start", int'(present_o), 0);
        check("R7", "tag after start", int'(chan_tag_o), tag);
    endtask

    // feeds samples first..last-1; bubbles carry a large invalid value
    task automatic feed(input int kind, input int first, input int last, input bit bubbles);
        for (int i = first; i < last; i++) begin
            if (bubbles && (i % 13 == 5)) begin
                @(negedge clk);
                mag_valid_i = 1'b0;
                mag_i = 24'hFFFFFF;
            end
            @(negedge clk);
            mag_valid_i = 1'b1;
            mag_i = MW'(samp(kind, i));
        end
    endtask

    task automatic run_window(input int kind, input int tag, input bit bubbles,
                              input int exp_pres, input string req);
        do_start(tag);
        feed(kind, 0, WIN - 1, bubbles);
        check("R3", "no early done", int'(done_o), 0);
        feed(kind, WIN - 1, WIN, 1'b0);
        @(negedge clk);
        mag_valid_i = 1'b0;
        check("R3", "done after last sample", int'(done_o), 1);
        check(req, "decision", int'(present_o), exp_pres);
        check("R7", "tag with result", int'(chan_tag_o), tag);
        @(negedge clk);
        check("R3", "done one cycle", int'(done_o), 0);
        check("R6", "present held", int'(present_o), exp_pres);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset done_o", int'(done_o), 0);
        check("R1", "reset present_o", int'(present_o), 0);
        check("R1", "reset chan_tag_o", int'(chan_tag_o), 0);
        rst = 1'b0;

        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            mag_valid_i = 1'b1;
            mag_i = 24'h00FFFF;
            check("R2", "idle samples ignored", int'(done_o), 0);
        end

        run_window(0, 0, 1'b1, 1, "R8");
        run_window(1, 1, 1'b0, 0, "R5");
        run_window(2, 2, 1'b1, 1, "R4");

        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            mag_valid_i = 1'b1;
            mag_i = 24'h7FFFFF;
            check("R2", "post-window samples ignored", int'(done_o), 0);
            check("R6", "present kept after window", int'(present_o), 1);
        end
        mag_valid_i = 1'b0;

        run_window(3, 3, 1'b0, 0, "R4");
        run_window(4, 0, 1'b0, 0, "R5");
        run_window(5, 1, 1'b0, 0, "R4");
        run_window(6, 2, 1'b0, 1, "R4");

        do_start(3);
        feed(3, 0, 1000, 1'b0);
        run_window(0, 2, 1'b0, 1, "R9");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule